// File: doc/BRIEF.md
# Memory-Mapped Console Register Controller

This block is a console peripheral that sits on a 32-bit register bus. Software can push one output character at a time straight to a transmit byte stream. Bytes from the serial side queue up in a receive FIFO, and software reads the FIFO fill level from a status register. A command register does two jobs: it turns the level interrupt on and off, and it starts whole-buffer transfers. A separate DMA mover carries out those transfers. The controller supplies that mover with a 64-bit memory address, a byte length and a direction. It holds the bus access open until the mover reports completion. For a receive transfer, the mover drains bytes from the FIFO through a pop port.

There is no mask register. The interrupt follows a pair of commands, and its line tracks FIFO occupancy only at three moments: when it is switched on, when a byte arrives, and when a receive transfer completes.

Register offsets, as byte addresses:

| Offset | Access | Meaning |
|--------|--------|---------|
| 0x00 | write | output character |
| 0x04 | read | receive count |
| 0x08 | write | command |
| 0x10 | write | address low |
| 0x14 | write | length |
| 0x18 | write | address high |
| 0x20 | read | version |

Top module: `mmio_console`

## Requirements
- R1: After reset the receive FIFO is empty, the interrupt is disabled with `irq` low, and both the transfer address and the transfer length read as zero.
- R2: A read of offset 0x20 returns 1. A read of any offset other than 0x04 and 0x20 returns 0.
- R3: `rx_ready` is high exactly when the FIFO holds fewer than DEPTH bytes, and a byte is stored only on a cycle where `rx_valid` and `rx_ready` are both high. A read of offset 0x04 returns the stored byte count, zero-extended to 32 bits.
- R4: A write to offset 0x00 presents `bus_wdata[7:0]` on `tx_data` with `tx_valid` high, and holds `bus_ready` low until `tx_ready` is high.
- R5: Command value 1, issued while the interrupt is disabled, enables it. `irq` rises on the next cycle if the FIFO holds a byte or a byte arrives on that same cycle. Otherwise `irq` stays low.
- R6: Command value 0, issued while the interrupt is enabled, disables it and drops `irq` on the next cycle. Command 1 while enabled and command 0 while disabled change nothing.
- R7: A byte stored while the interrupt is enabled raises `irq` on the next cycle. A byte stored while the interrupt is disabled leaves `irq` low.
- R8: A write to offset 0x10 sets `dma_addr` to the written word zero-extended to 64 bits. A write to offset 0x18 replaces only `dma_addr[63:32]`.
- R9: A write to offset 0x14 sets `dma_len`. Command value 2 raises `dma_start` with `dma_to_mem` low, and the bus access completes only on a cycle where `dma_done` is high.
- R10: Command value 3 raises `dma_start` with `dma_to_mem` high. While it runs, each `dma_pop` removes the oldest byte, which is shown on `dma_pop_data`. When the command completes with the interrupt enabled and the FIFO empty afterwards, `irq` drops.
- R11: Writes to undefined offsets, to the read-only offsets 0x04 and 0x20, and command values above 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid during a read access |
| bus_ready | output | 1 | access completes on this cycle |
| tx_valid | output | 1 | output character present |
| tx_data | output | 8 | output character |
| tx_ready | input | 1 | character taken |
| rx_valid | input | 1 | incoming byte present |
| rx_data | input | 8 | incoming byte |
| rx_ready | output | 1 | FIFO has space |
| irq | output | 1 | level interrupt |
| dma_start | output | 1 | transfer requested, held until done |
| dma_to_mem | output | 1 | 1 = FIFO to memory, 0 = memory to output |
| dma_addr | output | 64 | transfer address |
| dma_len | output | 32 | transfer length in bytes |
| dma_done | input | 1 | transfer complete |
| dma_pop | input | 1 | mover takes the oldest FIFO byte |
| dma_pop_data | output | 8 | oldest FIFO byte |
| dma_pop_valid | output | 1 | FIFO not empty |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, a few bytes fill the FIFO, so the full-FIFO backpressure on `rx_ready` and the count reaching its maximum are both exercised. The bench also drains the FIFO completely inside a receive command, and that drain is what drops the interrupt. ADDR_W stays at 6, so every offset in the window can be driven, along with the first offset past it.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int unsigned OFF_TXCHAR  = 'h00;
  localparam int unsigned OFF_RXCOUNT = 'h04;
  localparam int unsigned OFF_CMD     = 'h08;
  localparam int unsigned OFF_ADDR_LO = 'h10;
  localparam int unsigned OFF_LEN     = 'h14;
  localparam int unsigned OFF_ADDR_HI = 'h18;
  localparam int unsigned OFF_VERSION = 'h20;
  localparam logic [31:0] VERSION_ID  = 32'd1;

  typedef enum logic [31:0] {
    CMD_IRQ_OFF  = 32'd0,
    CMD_IRQ_ON   = 32'd1,
    CMD_SEND_BUF = 32'd2,
    CMD_RECV_BUF = 32'd3
  } con_cmd_e;

  function automatic logic cmd_is_xfer(input logic [31:0] code);
    return (code == CMD_SEND_BUF) || (code == CMD_RECV_BUF);
  endfunction

  function automatic logic [63:0] set_hi_word(input logic [63:0] cur, input logic [31:0] w);
    return {w, cur[31:0]};
  endfunction

  function automatic logic [63:0] set_lo_word(input logic [31:0] w);
    return {32'h0, w};
  endfunction
endpackage

// File: rtl/con_rx_fifo.sv
module con_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/con_xfer_regs.sv
module con_xfer_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wr_len,
  input  logic [31:0] wdata,
  output logic [63:0] addr,
  output logic [31:0] len
);
  import con_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      len  <= '0;
    end else begin
      if (wr_lo)       addr <= set_lo_word(wdata);
      else if (wr_hi)  addr <= set_hi_word(addr, wdata);
      if (wr_len)      len  <= wdata;
    end
  end
endmodule

// File: rtl/con_irq_gate.sv
module con_irq_gate #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_off,
  input  logic             cmd_on,
  input  logic             rx_push,
  input  logic             recv_done,
  input  logic [CNT_W-1:0] cnt_now,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             irq_en,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      irq    <= 1'b0;
    end else if (cmd_off && irq_en) begin
      irq_en <= 1'b0;
      irq    <= 1'b0;
    end else if (cmd_on && !irq_en) begin
      irq_en <= 1'b1;
      irq    <= (cnt_now != '0) || rx_push;
    end else if (rx_push && irq_en) begin
      irq    <= 1'b1;
    end else if (recv_done && irq_en && cnt_next == '0) begin
      irq    <= 1'b0;
    end
  end
endmodule

// File: rtl/mmio_console.sv
module mmio_console #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              irq,
  output logic              dma_start,
  output logic              dma_to_mem,
  output logic [63:0]       dma_addr,
  output logic [31:0]       dma_len,
  input  logic              dma_done,
  input  logic              dma_pop,
  output logic [7:0]        dma_pop_data,
  output logic              dma_pop_valid
);
  import con_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [31:0]      off;
  logic             hit_tx, hit_cmd, hit_xfer, wr_fire;
  logic             cmd_off_fire, cmd_on_fire, recv_done;
  logic             lo_fire, hi_fire, len_fire;
  logic             rx_push, rx_pop;
  logic [CNT_W-1:0] rx_count, rx_count_next;
  logic             rx_full, rx_empty, irq_en;

  assign off      = 32'(bus_addr);
  assign hit_tx   = bus_sel && bus_wr && (off == OFF_TXCHAR);
  assign hit_cmd  = bus_sel && bus_wr && (off == OFF_CMD);
  assign hit_xfer = hit_cmd && cmd_is_xfer(bus_wdata);

  always_comb begin
    if (hit_tx)        bus_ready = tx_ready;
    else if (hit_xfer) bus_ready = dma_done;
    else               bus_ready = 1'b1;
  end

  assign wr_fire      = bus_sel && bus_wr && bus_ready;
  assign cmd_off_fire = wr_fire && (off == OFF_CMD) && (bus_wdata == CMD_IRQ_OFF);
  assign cmd_on_fire  = wr_fire && (off == OFF_CMD) && (bus_wdata == CMD_IRQ_ON);
  assign recv_done    = wr_fire && (off == OFF_CMD) && (bus_wdata == CMD_RECV_BUF);
  assign lo_fire      = wr_fire && (off == OFF_ADDR_LO);
  assign hi_fire      = wr_fire && (off == OFF_ADDR_HI);
  assign len_fire     = wr_fire && (off == OFF_LEN);

  assign tx_valid   = hit_tx;
  assign tx_data    = bus_wdata[7:0];
  assign dma_start  = hit_xfer;
  assign dma_to_mem = (bus_wdata == CMD_RECV_BUF);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (off == OFF_RXCOUNT)      bus_rdata = 32'(rx_count);
      else if (off == OFF_VERSION) bus_rdata = VERSION_ID;
    end
  end

  assign rx_ready      = !rx_full;
  assign rx_push       = rx_valid && !rx_full;
  assign rx_pop        = dma_pop && !rx_empty;
  assign rx_count_next = rx_count + CNT_W'(rx_push) - CNT_W'(rx_pop);
  assign dma_pop_valid = !rx_empty;

  con_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_data),
    .pop(rx_pop), .head(dma_pop_data), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  con_xfer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(lo_fire), .wr_hi(hi_fire),
    .wr_len(len_fire), .wdata(bus_wdata), .addr(dma_addr), .len(dma_len)
  );

  con_irq_gate #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .cmd_off(cmd_off_fire), .cmd_on(cmd_on_fire),
    .rx_push(rx_push), .recv_done(recv_done), .cnt_now(rx_count),
    .cnt_next(rx_count_next), .irq_en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/con_chk.sv
module con_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              irq,
  input logic              irq_en,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_push,
  input logic              cmd_off_fire,
  input logic              cmd_on_fire,
  input logic              hi_fire,
  input logic [63:0]       dma_addr
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CNT_W'(DEPTH)) |-> !rx_ready);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  assert_tx_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |-> !bus_ready);

  assert_irq_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on_fire && !irq_en && rx_count != '0) |=> irq);

  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off_fire |=> (!irq && !irq_en));

  assert_rx_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && irq_en && !cmd_off_fire) |=> irq);

  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_hi_keeps_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_fire |=> (dma_addr[31:0] == $past(dma_addr[31:0])));

  assert_version_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && 32'(bus_addr) == 32'h20) |-> (bus_rdata == 32'd1));
endmodule

bind mmio_console con_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_con_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .irq(irq), .irq_en(irq_en), .rx_count(rx_count), .rx_push(rx_push),
  .cmd_off_fire(cmd_off_fire), .cmd_on_fire(cmd_on_fire),
  .hi_fire(hi_fire), .dma_addr(dma_addr)
);

// File: tb/mmio_console_bench.sv
module mmio_console_bench;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 6;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, tx_valid, tx_ready = 1;
  logic [7:0] tx_data, rx_data = '0, dma_pop_data;
  logic rx_valid = 0, rx_ready, irq;
  logic dma_start, dma_to_mem, dma_done = 0, dma_pop = 0, dma_pop_valid;
  logic [63:0] dma_addr;
  logic [31:0] dma_len;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mmio_console #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mmio_console (.*);

  // behavioural reference state
  logic [7:0]  q[$];
  bit          m_en, m_irq;
  logic [63:0] m_ptr;
  logic [31:0] m_len;
  int          m_cnt, m_off;
  bit          m_push, m_pop, m_rdy, m_fire;

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_en = 0; m_irq = 0; m_ptr = '0; m_len = '0;
    end else begin
      m_cnt  = q.size();
      m_off  = int'(bus_addr);
      m_push = rx_valid && (m_cnt < DEPTH);
      m_pop  = dma_pop && (m_cnt > 0);
      if (bus_sel && bus_wr && m_off == 0) m_rdy = tx_ready;
      else if (bus_sel && bus_wr && m_off == 8 && (bus_wdata == 2 || bus_wdata == 3)) m_rdy = dma_done;
      else m_rdy = 1;
      m_fire = bus_sel && bus_wr && m_rdy;
      if (m_pop) void'(q.pop_front());
      if (m_push) q.push_back(rx_data);
      if (m_fire && m_off == 8 && bus_wdata == 0 && m_en) begin
        m_en = 0; m_irq = 0;
      end else if (m_fire && m_off == 8 && bus_wdata == 1 && !m_en) begin
        m_en = 1; m_irq = (m_cnt > 0) || m_push;
      end else if (m_push && m_en) begin
        m_irq = 1;
      end else if (m_fire && m_off == 8 && bus_wdata == 3 && m_en && q.size() == 0) begin
        m_irq = 0;
      end
      if (m_fire && m_off == 'h10) m_ptr = {32'h0, bus_wdata};
      if (m_fire && m_off == 'h18) m_ptr[63:32] = bus_wdata;
      if (m_fire && m_off == 'h14) m_len = bus_wdata;
    end
    #2;
    check(irq == m_irq, "R5/R6/R7/R10 irq", 64'(irq), 64'(m_irq));
    check(rx_ready == (q.size() < DEPTH), "R3 rx_ready", 64'(rx_ready), 64'(q.size() < DEPTH));
    check(dma_addr == m_ptr, "R8 dma_addr", dma_addr, m_ptr);
    check(dma_len == m_len, "R9 dma_len", 64'(dma_len), 64'(m_len));
    check(dma_pop_valid == (q.size() > 0), "R10 pop_valid", 64'(dma_pop_valid), 64'(q.size() > 0));
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(a);
    #1;
    check(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
    bus_sel = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic tx_char(input logic [31:0] d, input int stall);
    @(negedge clk);
    tx_ready = 0; bus_sel = 1; bus_wr = 1; bus_addr = '0; bus_wdata = d;
    #1;
    check(tx_valid == 1, "R4 tx_valid", 64'(tx_valid), 64'd1);
    check(tx_data == d[7:0], "R4 tx_data", 64'(tx_data), 64'(d[7:0]));
    for (int i = 0; i < stall; i++) begin
      check(bus_ready == 0, "R4 stall", 64'(bus_ready), 64'd0);
      @(negedge clk);
    end
    tx_ready = 1;
    #1;
    check(bus_ready == 1, "R4 release", 64'(bus_ready), 64'd1);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic xfer(input logic [31:0] cmd, input int npop);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(8); bus_wdata = cmd;
    #1;
    check(dma_start == 1, "R9 dma_start", 64'(dma_start), 64'd1);
    check(dma_to_mem == (cmd == 3), "R9/R10 direction", 64'(dma_to_mem), 64'(cmd == 3));
    check(bus_ready == 0, "R9 wait done", 64'(bus_ready), 64'd0);
    for (int i = 0; i < npop; i++) begin
      dma_pop = 1;
      #1;
      if (q.size() > 0)
        check(dma_pop_data == q[0], "R10 pop order", 64'(dma_pop_data), 64'(q[0]));
      @(negedge clk);
    end
    dma_pop = 0; dma_done = 1;
    @(negedge clk);
    dma_done = 0; bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_read('h04, 0, "R1 count after reset");
    check(irq == 0, "R1 irq", 64'(irq), 0);
    check(dma_addr == 0 && dma_len == 0, "R1 regs", dma_addr, 0);
    // R2 reads
    bus_read('h20, 1, "R2 version");
    bus_read('h0C, 0, "R2 undefined");
    bus_read('h24, 0, "R2 past window");
    bus_read('h10, 0, "R2 write-only reads 0");
    // R8 address words
    bus_write('h10, 32'h1234_5678);
    bus_write('h18, 32'h9ABC_DEF0);
    @(negedge clk);
    check(dma_addr == 64'h9ABC_DEF0_1234_5678, "R8 hi write", dma_addr, 64'h9ABC_DEF0_1234_5678);
    bus_write('h10, 32'h1111_0000);
    @(negedge clk);
    check(dma_addr == 64'h1111_0000, "R8 lo write", dma_addr, 64'h1111_0000);
    bus_write('h18, 32'hA5);
    bus_write('h14, 32'd5);
    // R11 ignored writes
    bus_write('h0C, 32'hFFFF_FFFF);
    bus_write('h1C, 32'hFFFF_FFFF);
    bus_write('h20, 32'h7);
    bus_write('h04, 32'h3);
    bus_write('h08, 32'h7);
    bus_read('h20, 1, "R11 version unchanged");
    bus_read('h04, 0, "R11 count unchanged");
    check(irq == 0, "R11 irq unchanged", 64'(irq), 0);
    // R7 negative, R3 count
    send_byte(8'h41);
    send_byte(8'h42);
    check(irq == 0, "R7 disabled stays low", 64'(irq), 0);
    bus_read('h04, 2, "R3 count two");
    // R5 enable with data, repeat
    bus_write('h08, 1);
    @(negedge clk);
    check(irq == 1, "R5 enable raises", 64'(irq), 1);
    bus_write('h08, 1);
    // R6 disable, repeat
    bus_write('h08, 0);
    @(negedge clk);
    check(irq == 0, "R6 disable drops", 64'(irq), 0);
    bus_write('h08, 0);
    bus_write('h08, 1);
    // R3 fill to full with held valid
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h43;
    @(negedge clk); rx_data = 8'h44;
    @(negedge clk); rx_data = 8'h45;
    @(negedge clk);
    check(rx_ready == 0, "R3 full backpressure", 64'(rx_ready), 0);
    @(negedge clk);
    rx_valid = 0;
    bus_read('h04, DEPTH, "R3 count at depth");
    // R9 transmit command, R4 character
    xfer(2, 0);
    tx_char(32'hABCD_EF5A, 2);
    tx_char(32'h33, 0);
    // R10 receive draining all
    xfer(3, DEPTH);
    check(irq == 0, "R10 drain drops irq", 64'(irq), 0);
    bus_read('h04, 0, "R10 count empty");
    // R5 enable when empty
    bus_write('h08, 0);
    bus_write('h08, 1);
    @(negedge clk);
    check(irq == 0, "R5 enable empty stays low", 64'(irq), 0);
    // R7 arrival raises
    send_byte(8'h61);
    check(irq == 1, "R7 arrival raises", 64'(irq), 1);
    send_byte(8'h62);
    // R10 partial receive keeps irq
    xfer(3, 1);
    check(irq == 1, "R10 partial keeps irq", 64'(irq), 1);
    // pop outside a command: irq is not recomputed
    @(negedge clk); dma_pop = 1;
    @(negedge clk); dma_pop = 0;
    check(irq == 1, "R6 no recompute on pop", 64'(irq), 1);
    bus_write('h08, 1);
    check(irq == 1, "R6 repeat enable no effect", 64'(irq), 1);
    xfer(3, 0);
    check(irq == 0, "R10 empty receive drops", 64'(irq), 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule